// File: doc/BRIEF.md
# Fixed-Point Saturating PID Controller

This block computes one update of a discrete-time PID control law each time a sample strobe arrives. The error is the voltage reference minus the measured voltage. The block keeps a running sum of past errors and remembers the previous error so that it can form a backward difference. The proportional, integral and derivative terms are each scaled by a Q8.8 gain and then added into one Q8.8 control command. This command can drive a PWM duty setting or a timing command.

The voltage and current samples come from external converters and are already aligned to the controller clock. Every arithmetic step clamps at its signed limits and never wraps. Each update takes a fixed number of clocks, whatever the data values are. The three gains are quasi-static register inputs and must be held stable while an update is in progress. The current sample is captured with the voltage data and presented on a status output. It does not enter the control law.

Top module: `pid_ctrl`

## Requirements
- R1: After the active-low asynchronous reset, `u_o`, `out_valid_o` and `i_meas_o` are zero, and the integral sum and the stored previous error are zero.
- R2: The error is e = vref_i - v_meas_i, taken as 16-bit signed Q8.8 and clamped to the range -32768..32767 in raw integer terms.
- R3: The proportional term is (kp_i * e) arithmetically shifted right by 8 and clamped to 16 bits. `u_o` is the sum P + I + D clamped to 16 bits.
- R4: The integral sum adds e on every accepted update and includes the current e. The integral term is (ki_i * sum) shifted right by 8 and clamped to 16 bits.
- R5: The derivative term is (kd_i * clamp16(e - e_prev)) shifted right by 8 and clamped to 16 bits. e_prev is the error of the previous completed update.
- R6: When an intermediate or final value goes past a 16-bit signed limit, it clamps to 32767 or -32768 and does not wrap.
- R7: A sample strobe that is accepted in cycle c produces a one-cycle `out_valid_o` pulse in cycle c+3, and `u_o` takes its new value in that same cycle. `u_o` holds its value in every other cycle.
- R8: A sample strobe in the two cycles after an accepted one is ignored. It produces no extra pulse and changes neither `u_o`, `i_meas_o` nor the stored error or integral state.
- R9: `i_meas_o` takes the value of `i_meas_i` from the accepted strobe one cycle after acceptance. The current sample has no effect on `u_o`.
- R10: The integral sum is 24-bit signed and clamps at 8388607 and -8388608. Once it has saturated, an opposite error reduces it at once, starting from the clamped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Starts one update when the block is idle |
| vref_i | input | 16 | Voltage reference, signed Q8.8 |
| v_meas_i | input | 16 | Measured voltage, signed Q8.8 |
| i_meas_i | input | 16 | Measured current, signed Q8.8 |
| kp_i | input | 16 | Proportional gain, signed Q8.8 |
| ki_i | input | 16 | Integral gain, signed Q8.8 |
| kd_i | input | 16 | Derivative gain, signed Q8.8 |
| u_o | output | 16 | Control command, signed Q8.8 |
| out_valid_o | output | 1 | One-cycle strobe marking a new command |
| i_meas_o | output | 16 | Captured current sample (status) |

## Verification
The result of a strobe accepted in cycle c is due in cycle c+3. The bench drives each strobe just after a falling edge. It then samples at the next three falling edges:
- At the first falling edge it expects the strobe low and the captured current already present.
- At the second falling edge it expects the strobe still low.
- At the third falling edge it expects the strobe high, with the command equal to the value from the bench's own clamped model.

For ignored strobes, the bench watches for three further cycles. It checks that no pulse appears and that the command and the status output hold. The next accepted update then shows that the previous error and the integral sum were left untouched.

// File: rtl/pid_pkg.sv
package pid_pkg;
  localparam int DATA_W = 16;  // Q8.8 samples, gains and command
  localparam int FRAC_W = 8;
  localparam int ACC_W  = 24;  // integral sum, Q16.8
endpackage

// File: rtl/pid_sat.sv
module pid_sat #(
  parameter int IN_W  = 17,
  parameter int OUT_W = 16
) (
  input  logic signed [IN_W-1:0]  din_i,
  output logic signed [OUT_W-1:0] dout_o
);
  generate
    if (IN_W > OUT_W) begin : g_clip
      localparam int HI_W = IN_W - OUT_W + 1;
      logic [HI_W-1:0] hi_bits;
      assign hi_bits = din_i[IN_W-1:OUT_W-1];
      always_comb begin
        if (&hi_bits || ~|hi_bits) dout_o = din_i[OUT_W-1:0];
        else if (din_i[IN_W-1])    dout_o = {1'b1, {(OUT_W-1){1'b0}}};
        else                       dout_o = {1'b0, {(OUT_W-1){1'b1}}};
      end
    end else if (IN_W == OUT_W) begin : g_pass
      assign dout_o = din_i;
    end else begin : g_ext
      assign dout_o = {{(OUT_W-IN_W){din_i[IN_W-1]}}, din_i};
    end
  endgenerate
endmodule

// File: rtl/pid_mul_scale.sv
module pid_mul_scale #(
  parameter int A_W   = 16,
  parameter int B_W   = 16,
  parameter int FRAC  = 8,
  parameter int OUT_W = 16
) (
  input  logic signed [A_W-1:0]   a_i,
  input  logic signed [B_W-1:0]   b_i,
  output logic signed [OUT_W-1:0] y_o
);
  localparam int P_W = A_W + B_W;

  logic signed [P_W-1:0] prod;
  logic signed [P_W-1:0] scaled;

  // low P_W bits of a two's complement product do not depend on signedness
  assign prod   = {{B_W{a_i[A_W-1]}}, a_i} * {{A_W{b_i[B_W-1]}}, b_i};
  assign scaled = prod >>> FRAC;

  pid_sat #(.IN_W(P_W), .OUT_W(OUT_W)) u_sat (
    .din_i (scaled),
    .dout_o(y_o)
  );
endmodule

// File: rtl/pid_integ.sv
module pid_integ #(
  parameter int DW = 16,
  parameter int AW = 24
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] e_i,
  output logic signed [AW-1:0] acc_next_o
);
  logic signed [AW-1:0] acc_q;
  logic signed [AW:0]   acc_raw;

  assign acc_raw = {acc_q[AW-1], acc_q} + {{(AW+1-DW){e_i[DW-1]}}, e_i};

  pid_sat #(.IN_W(AW+1), .OUT_W(AW)) u_clamp (
    .din_i (acc_raw),
    .dout_o(acc_next_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= acc_next_o;
  end
endmodule

// File: rtl/pid_ctrl.sv
module pid_ctrl
  import pid_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int FW = FRAC_W,
  parameter int AW = ACC_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_valid_i,
  input  logic signed [DW-1:0] vref_i,
  input  logic signed [DW-1:0] v_meas_i,
  input  logic signed [DW-1:0] i_meas_i,
  input  logic signed [DW-1:0] kp_i,
  input  logic signed [DW-1:0] ki_i,
  input  logic signed [DW-1:0] kd_i,
  output logic signed [DW-1:0] u_o,
  output logic                 out_valid_o,
  output logic signed [DW-1:0] i_meas_o
);
  localparam int DIFF_W = DW + 1;
  localparam int SUM_W  = DW + 2;

  logic stage1_vld, stage2_vld, out_vld_q;
  logic accept;

  logic signed [DIFF_W-1:0] err_raw, dif_raw;
  logic signed [DW-1:0]     err_sat, dif_sat;
  logic signed [DW-1:0]     e_q, e_prev_q, i_meas_q;
  logic signed [AW-1:0]     acc_next;
  logic signed [DW-1:0]     p_term, i_term, d_term;
  logic signed [DW-1:0]     p_q, i_q, d_q;
  logic signed [SUM_W-1:0]  sum_raw;
  logic signed [DW-1:0]     u_next, u_q;

  // one update in flight at a time
  assign accept = sample_valid_i & ~stage1_vld & ~stage2_vld;

  // stage 1: error
  assign err_raw = {vref_i[DW-1], vref_i} - {v_meas_i[DW-1], v_meas_i};

  pid_sat #(.IN_W(DIFF_W), .OUT_W(DW)) u_err_sat (
    .din_i (err_raw),
    .dout_o(err_sat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_vld <= 1'b0;
      e_q        <= '0;
      i_meas_q   <= '0;
    end else begin
      stage1_vld <= accept;
      if (accept) begin
        e_q      <= err_sat;
        i_meas_q <= i_meas_i;
      end
    end
  end

  // stage 2: integral update and gain products
  pid_integ #(.DW(DW), .AW(AW)) u_integ (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (stage1_vld),
    .e_i       (e_q),
    .acc_next_o(acc_next)
  );

  assign dif_raw = {e_q[DW-1], e_q} - {e_prev_q[DW-1], e_prev_q};

  pid_sat #(.IN_W(DIFF_W), .OUT_W(DW)) u_dif_sat (
    .din_i (dif_raw),
    .dout_o(dif_sat)
  );

  pid_mul_scale #(.A_W(DW), .B_W(DW), .FRAC(FW), .OUT_W(DW)) u_mul_p (
    .a_i(kp_i),
    .b_i(e_q),
    .y_o(p_term)
  );

  pid_mul_scale #(.A_W(DW), .B_W(AW), .FRAC(FW), .OUT_W(DW)) u_mul_i (
    .a_i(ki_i),
    .b_i(acc_next),
    .y_o(i_term)
  );

  pid_mul_scale #(.A_W(DW), .B_W(DW), .FRAC(FW), .OUT_W(DW)) u_mul_d (
    .a_i(kd_i),
    .b_i(dif_sat),
    .y_o(d_term)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage2_vld <= 1'b0;
      p_q        <= '0;
      i_q        <= '0;
      d_q        <= '0;
    end else begin
      stage2_vld <= stage1_vld;
      if (stage1_vld) begin
        p_q <= p_term;
        i_q <= i_term;
        d_q <= d_term;
      end
    end
  end

  // stage 3: sum, clamp, commit previous error
  assign sum_raw = {{2{p_q[DW-1]}}, p_q} + {{2{i_q[DW-1]}}, i_q} + {{2{d_q[DW-1]}}, d_q};

  pid_sat #(.IN_W(SUM_W), .OUT_W(DW)) u_sum_sat (
    .din_i (sum_raw),
    .dout_o(u_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      u_q       <= '0;
      e_prev_q  <= '0;
    end else begin
      out_vld_q <= stage2_vld;
      if (stage2_vld) begin
        u_q      <= u_next;
        e_prev_q <= e_q;
      end
    end
  end

  assign u_o         = u_q;
  assign out_valid_o = out_vld_q;
  assign i_meas_o    = i_meas_q;
endmodule

// File: rtl/pid_ctrl_chk.sv
module pid_ctrl_chk #(
  parameter int DW = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 sample_valid_i,
  input logic                 stage1_vld,
  input logic                 stage2_vld,
  input logic                 out_valid_o,
  input logic signed [DW-1:0] u_o,
  input logic signed [DW-1:0] i_meas_i,
  input logic signed [DW-1:0] i_meas_o
);
  a_r7_fixed_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && !stage1_vld && !stage2_vld) |=> ##2 out_valid_o);

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  a_r7_u_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(u_o) |-> out_valid_o);

  a_r8_pulse_from_pipe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(stage2_vld));

  a_r8_busy_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && (stage1_vld || stage2_vld)) |=> $stable(i_meas_o));

  a_r9_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && !stage1_vld && !stage2_vld) |=> (i_meas_o == $past(i_meas_i)));
endmodule

bind pid_ctrl pid_ctrl_chk #(.DW(DW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sample_valid_i(sample_valid_i),
  .stage1_vld    (stage1_vld),
  .stage2_vld    (stage2_vld),
  .out_valid_o   (out_valid_o),
  .u_o           (u_o),
  .i_meas_i      (i_meas_i),
  .i_meas_o      (i_meas_o)
);

// File: tb/tb_pid_ctrl.sv
module tb_pid_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYC   = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sample_valid = 1'b0;
  logic signed [15:0] vref = '0, v_meas = '0, i_meas = '0;
  logic signed [15:0] kp = '0, ki = '0, kd = '0;
  logic signed [15:0] u_o, i_meas_o;
  logic out_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  longint m_integ = 0, m_eprev = 0, m_u = 0, m_i = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pid_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_valid_i(sample_valid),
    .vref_i(vref), .v_meas_i(v_meas), .i_meas_i(i_meas),
    .kp_i(kp), .ki_i(ki), .kd_i(kd),
    .u_o(u_o), .out_valid_o(out_valid_o), .i_meas_o(i_meas_o)
  );

  function automatic longint sat(input longint x, input int w);
    longint hi = (longint'(1) <<< (w-1)) - 1;
    longint lo = -(longint'(1) <<< (w-1));
    if (x > hi) return hi;
    if (x < lo) return lo;
    return x;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_gains(input longint p, input longint i, input longint d);
    @(negedge clk);
    kp = p[15:0]; ki = i[15:0]; kd = d[15:0];
  endtask

  // one accepted update, checked for timing and value
  task automatic do_sample(input longint vr, input longint vm, input longint im, input string req);
    longint e, p, it, d, u;
    e = sat(vr - vm, 16);
    m_integ = sat(m_integ + e, 24);
    p  = sat((longint'(kp) * e) >>> 8, 16);
    it = sat((longint'(ki) * m_integ) >>> 8, 16);
    d  = sat((longint'(kd) * sat(e - m_eprev, 16)) >>> 8, 16);
    u  = sat(p + it + d, 16);
    @(negedge clk);
    vref = vr[15:0]; v_meas = vm[15:0]; i_meas = im[15:0]; sample_valid = 1'b1;
    @(negedge clk);
    sample_valid = 1'b0;
    chk("R7 strobe low at c+1", out_valid_o, 0);
    chk("R9 current captured", longint'(i_meas_o), im);
    chk("R7 command held at c+1", longint'(u_o), m_u);
    @(negedge clk);
    chk("R7 strobe low at c+2", out_valid_o, 0);
    @(negedge clk);
    chk("R7 strobe high at c+3", out_valid_o, 1);
    chk(req, longint'(u_o), u);
    m_eprev = e; m_u = u; m_i = im;
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 u_o zero in reset", longint'(u_o), 0);
    chk("R1 strobe zero in reset", out_valid_o, 0);
    chk("R1 current status zero in reset", longint'(i_meas_o), 0);
    rst_ni = 1'b1;
    m_integ = 0; m_eprev = 0; m_u = 0; m_i = 0;
  endtask

  task automatic t_reset_state();
    apply_reset();
    set_gains(0, 0, 256);
    do_sample(1000, 200, 5, "R1 R5 derivative from cleared previous error");
  endtask

  task automatic t_proportional();
    set_gains(384, 0, 0);
    do_sample(2560, 512, 0, "R2 R3 positive error");
    do_sample(-700, 300, 1, "R2 R3 negative error");
    do_sample(0, 0, 2, "R3 zero error");
  endtask

  task automatic t_integral();
    set_gains(0, 256, 0);
    do_sample(300, 100, 0, "R4 sum first");
    do_sample(300, 100, 0, "R4 sum second");
    do_sample(-1000, 0, 0, "R4 sum reverse");
  endtask

  task automatic t_derivative();
    set_gains(0, 0, 512);
    do_sample(500, 0, 0, "R5 step up");
    do_sample(500, 0, 0, "R5 flat");
    do_sample(-500, 0, 0, "R5 step down");
  endtask

  task automatic t_saturation();
    set_gains(32767, 0, 0);
    do_sample(32767, -32768, 0, "R6 error and output clamp high");
    do_sample(-32768, 32767, 0, "R6 error and output clamp low");
    set_gains(0, 0, 32767);
    do_sample(32767, 0, 0, "R6 derivative clamp high");
    do_sample(-32768, 0, 0, "R6 derivative clamp low");
    set_gains(32767, 32767, 32767);
    do_sample(20000, 0, 0, "R6 sum clamp");
  endtask

  task automatic t_windup();
    apply_reset();
    set_gains(0, 1, 0);
    for (int k = 0; k < 260; k++) do_sample(32767, 0, 0, "R10 drive sum to limit");
    chk("R10 sum reached clamp", m_integ, 8388607);
    do_sample(-32768, 0, 0, "R10 recovery from clamped sum");
  endtask

  task automatic t_ignore_busy();
    longint e, u;
    set_gains(256, 128, 64);
    e = sat(1200 - 200, 16);
    m_integ = sat(m_integ + e, 24);
    u = sat(sat((longint'(kp) * e) >>> 8, 16) +
            sat((longint'(ki) * m_integ) >>> 8, 16) +
            sat((longint'(kd) * sat(e - m_eprev, 16)) >>> 8, 16), 16);
    @(negedge clk);
    vref = 1200; v_meas = 200; i_meas = 77; sample_valid = 1'b1;
    @(negedge clk);
    vref = -9000; v_meas = 9000; i_meas = -55;
    chk("R8 no strobe c+1", out_valid_o, 0);
    @(negedge clk);
    chk("R8 no strobe c+2", out_valid_o, 0);
    sample_valid = 1'b0;
    @(negedge clk);
    chk("R8 strobe at c+3", out_valid_o, 1);
    chk("R8 command from accepted sample", longint'(u_o), u);
    chk("R8 current from accepted sample", longint'(i_meas_o), 77);
    m_eprev = e; m_u = u; m_i = 77;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8 no extra strobe", out_valid_o, 0);
      chk("R8 command held", longint'(u_o), u);
      chk("R8 status held", longint'(i_meas_o), 77);
    end
    do_sample(1200, 200, 3, "R8 state untouched by ignored strobes");
  endtask

  task automatic t_current_ignored();
    set_gains(300, 20, 40);
    do_sample(400, 100, 32767, "R9 current high no effect");
    do_sample(400, 100, -32768, "R9 current low no effect");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", WDOG_CYC);
      summary();
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_proportional();
    t_integral();
    t_derivative();
    t_saturation();
    t_ignore_busy();
    t_current_ignored();
    t_windup();
    t_reset_state();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule